// File: doc/BRIEF.md
# Transmit Frame Status Collector

This block sits beside an Ethernet transmit MAC and builds a status record for each outgoing frame. A frame can take several attempts when collisions force retries. The collector follows the byte stream the MAC sends: the destination address, the length/type field and the payload count. It also takes in the events the MAC reports: deferral, collisions, host underrun, successful completion and abort after too many collisions. From these it works out a set of flags and a running byte total. CRC generation, the line pins and the retry/backoff logic are outside the block; their outcomes arrive only as event pulses.

Time is measured in line ticks supplied by the MAC. In 100 Mb/s mode a tick is one nibble time. In 10 Mb/s mode a tick is one bit time. The speed input picks the excessive-defer limit and the collision window in ticks.

The record for the frame in progress is kept in working registers. The cycle after the frame finishes or aborts, that record is copied as one unit into two output registers: a flag word and a byte count. These outputs keep the last record until the next frame ends.

Top module: `txsv_collect`

## Requirements
- R1: After a synchronous reset, `stat_flags` and `stat_bytes` are all zero.
- R2: The outputs change only on the clock edge that samples `frame_done` or `frame_abort`, and they are valid in the next cycle. `frame_new` clears the working record but leaves the outputs unchanged until the next end.
- R3: Bit 0 (done) is set when a frame ends through `frame_done`. Bit 9 (max-collision abort) is set instead when it ends through `frame_abort`. If both are high in the same cycle, the abort wins.
- R4: Bit 1 (broadcast) is set when all six destination bytes, which are the first six bytes of an attempt, are 0xFF and all six were sent.
- R5: Bit 2 (multicast) is set when bit 0 of the first destination byte is 1 and bit 1 is clear.
- R6: Bit 3 (VLAN) is set when bytes 12 and 13 of an attempt, read high byte first, equal 0x8100.
- R7: Bit 4 (length out of range) is set when that field is above `MAX_LEN` (1500).
- R8: Bit 5 (length mismatch) is set only on a done frame whose field is at most 1500. The data count, which is the final attempt's bytes minus 14, must differ from the field. A field below 46 with exactly 46 data bytes counts as a match.
- R9: Bit 7 (excessive defer) is set when one deferral period contains more ticks than the limit. The limit is `DEF_LIM_NIB` at 100 Mb/s and `DEF_LIM_BIT` at 10 Mb/s. Bit 6 (deferred) is set when the frame saw at least one defer tick but bit 7 is clear.
- R10: Bit 8 (late collision) is set when a collision arrives after at least W ticks since the attempt started. W is `WIN_BITS`/4 at 100 Mb/s and `WIN_BITS` at 10 Mb/s.
- R11: Bit 10 (underrun) is set if `underrun` pulsed during the frame.
- R12: `stat_bytes` is the number of bytes sent in all attempts of the frame, modulo 2^`CNT_W`.
- R13: Event flags gathered in a collided attempt stay set through later attempts of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_100 | input | 1 | 1: 100 Mb/s nibble ticks, 0: 10 Mb/s bit ticks |
| tick | input | 1 | One line time unit elapsed |
| frame_new | input | 1 | Pulse: a new frame begins, clears the working record |
| defer_active | input | 1 | High while the MAC defers |
| attempt_start | input | 1 | Pulse: a transmit attempt begins |
| tx_vld | input | 1 | A frame byte is sent this cycle |
| tx_byte | input | 8 | Byte value, destination address first |
| collision | input | 1 | Pulse: collision in the current attempt |
| underrun | input | 1 | Pulse: host starved the transmitter |
| frame_done | input | 1 | Pulse: frame completed |
| frame_abort | input | 1 | Pulse: frame dropped after too many collisions |
| stat_flags | output | 11 | Latched flag word, bit map in R3-style tags above |
| stat_bytes | output | CNT_W | Latched total byte count |

## Verification
The bench builds the collector with `DEF_LIM_NIB`=20, `DEF_LIM_BIT`=50 and `WIN_BITS`=64. With these values both excessive-defer limits and both collision windows (16 and 64 ticks) can be crossed in a few dozen cycles. As a result, random frames land on either side of every timing threshold at both speeds, and directed frames hit the exact boundary tick. `CNT_W` stays at 16, so one directed frame of 65544 bytes drives the byte total through its wrap.

// File: rtl/txsv_pkg.sv
package txsv_pkg;
  localparam int FLAG_W = 11;

  // first member is the MSB: underrun is bit 10, done is bit 0
  typedef struct packed {
    logic underrun;
    logic max_col;
    logic late_col;
    logic exc_defer;
    logic pkt_defer;
    logic len_chk;
    logic len_oor;
    logic vlan;
    logic mcast;
    logic bcast;
    logic done;
  } txsv_flags_t;
endpackage

// File: rtl/txsv_hdr_decode.sv
module txsv_hdr_decode #(
  parameter int          CNT_W       = 16,
  parameter int          MAX_LEN     = 1500,
  parameter int          HDR_BYTES   = 14,
  parameter int          MIN_PAYLOAD = 46,
  parameter logic [15:0] VLAN_ID     = 16'h8100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_new,
  input  logic       attempt_start,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  output logic       is_bcast,
  output logic       is_mcast,
  output logic       is_vlan,
  output logic       len_oor,
  output logic       len_bad
);
  localparam logic [CNT_W-1:0] P_DA_LAST = CNT_W'(5);
  localparam logic [CNT_W-1:0] P_HDR     = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] P_TYPE_HI = CNT_W'(HDR_BYTES - 2);
  localparam logic [CNT_W-1:0] P_TYPE_LO = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] P_MINPAY  = CNT_W'(MIN_PAYLOAD);
  localparam logic [CNT_W-1:0] P_CNT_MAX = '1;
  localparam logic [15:0]      P_MAXLEN  = 16'(MAX_LEN);

  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] data_cnt;
  logic [CNT_W-1:0] field_ext;
  logic             da_ones, da_full, first_lsb, first_seen, type_seen;
  logic [15:0]      type_f;

  always_ff @(posedge clk) begin
    if (rst || frame_new) begin
      idx        <= '0;
      da_ones    <= 1'b1;
      da_full    <= 1'b0;
      first_lsb  <= 1'b0;
      first_seen <= 1'b0;
      type_seen  <= 1'b0;
      type_f     <= '0;
    end else begin
      if (attempt_start)
        idx <= '0;
      else if (byte_vld && idx != P_CNT_MAX)
        idx <= idx + 1'b1;
      if (byte_vld && !attempt_start) begin
        if (idx == '0) begin
          first_lsb  <= byte_dat[0];
          first_seen <= 1'b1;
        end
        if (idx <= P_DA_LAST && byte_dat != 8'hFF) da_ones <= 1'b0;
        if (idx == P_DA_LAST) da_full <= 1'b1;
        if (idx == P_TYPE_HI) type_f[15:8] <= byte_dat;
        if (idx == P_TYPE_LO) begin
          type_f[7:0] <= byte_dat;
          type_seen   <= 1'b1;
        end
      end
    end
  end

  assign data_cnt  = (idx >= P_HDR) ? idx - P_HDR : '0;
  assign field_ext = CNT_W'(type_f);
  assign is_bcast  = da_ones & da_full;
  assign is_mcast  = first_seen & first_lsb & ~is_bcast;
  assign is_vlan   = type_seen && (type_f == VLAN_ID);
  assign len_oor   = type_seen && (type_f > P_MAXLEN);
  assign len_bad   = type_seen && !len_oor && (data_cnt != field_ext) &&
                     !((field_ext < P_MINPAY) && (data_cnt == P_MINPAY));

  AST_BCAST_NEEDS_SEEN: assert property (@(posedge clk) disable iff (rst)
    is_bcast |-> first_seen);  // R4
endmodule

// File: rtl/txsv_timer.sv
module txsv_timer #(
  parameter int LIM_NIB  = 6071,
  parameter int LIM_BIT  = 24287,
  parameter int WIN_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_new,
  input  logic speed_100,
  input  logic tick,
  input  logic defer_active,
  input  logic attempt_start,
  input  logic collision,
  output logic defer_seen,
  output logic defer_exc,
  output logic late_hit
);
  localparam int LIM_TOP = (LIM_NIB > LIM_BIT) ? LIM_NIB : LIM_BIT;
  localparam int DW      = $clog2(LIM_TOP + 1);
  localparam int PW      = $clog2(WIN_BITS + 1);

  logic [DW-1:0] dcnt, dlim;
  logic [PW-1:0] pos, win;

  assign dlim = speed_100 ? DW'(LIM_NIB) : DW'(LIM_BIT);
  assign win  = speed_100 ? PW'(WIN_BITS / 4) : PW'(WIN_BITS);

  // ticks in the current deferral period, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || frame_new || !defer_active)
      dcnt <= '0;
    else if (tick && dcnt < dlim)
      dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || frame_new) begin
      defer_seen <= 1'b0;
      defer_exc  <= 1'b0;
    end else begin
      if (defer_active && tick) defer_seen <= 1'b1;
      if (defer_active && tick && dcnt >= dlim) defer_exc <= 1'b1;
    end
  end

  // ticks since the attempt began, saturating at the window
  always_ff @(posedge clk) begin
    if (rst || attempt_start)
      pos <= '0;
    else if (tick && pos < win)
      pos <= pos + 1'b1;
  end

  assign late_hit = collision && (pos >= win);

  AST_EXC_NEEDS_SEEN: assert property (@(posedge clk) disable iff (rst)
    defer_exc |-> defer_seen);  // R9
endmodule

// File: rtl/txsv_collect.sv
module txsv_collect
  import txsv_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MAX_LEN     = 1500,
  parameter int HDR_BYTES   = 14,
  parameter int MIN_PAYLOAD = 46,
  parameter int DEF_LIM_NIB = 6071,
  parameter int DEF_LIM_BIT = 24287,
  parameter int WIN_BITS    = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              speed_100,
  input  logic              tick,
  input  logic              frame_new,
  input  logic              defer_active,
  input  logic              attempt_start,
  input  logic              tx_vld,
  input  logic [7:0]        tx_byte,
  input  logic              collision,
  input  logic              underrun,
  input  logic              frame_done,
  input  logic              frame_abort,
  output logic [FLAG_W-1:0] stat_flags,
  output logic [CNT_W-1:0]  stat_bytes
);
  logic             is_bcast, is_mcast, is_vlan, len_oor, len_bad;
  logic             defer_seen, defer_exc, late_hit;
  logic             late_acc, undr_acc, frame_end;
  logic [CNT_W-1:0] total;
  txsv_flags_t      rec, stat_r;

  txsv_hdr_decode #(
    .CNT_W(CNT_W), .MAX_LEN(MAX_LEN), .HDR_BYTES(HDR_BYTES),
    .MIN_PAYLOAD(MIN_PAYLOAD), .VLAN_ID(16'h8100)
  ) u_hdr (
    .clk(clk), .rst(rst), .frame_new(frame_new), .attempt_start(attempt_start),
    .byte_vld(tx_vld), .byte_dat(tx_byte),
    .is_bcast(is_bcast), .is_mcast(is_mcast), .is_vlan(is_vlan),
    .len_oor(len_oor), .len_bad(len_bad)
  );

  txsv_timer #(
    .LIM_NIB(DEF_LIM_NIB), .LIM_BIT(DEF_LIM_BIT), .WIN_BITS(WIN_BITS)
  ) u_tmr (
    .clk(clk), .rst(rst), .frame_new(frame_new), .speed_100(speed_100),
    .tick(tick), .defer_active(defer_active), .attempt_start(attempt_start),
    .collision(collision), .defer_seen(defer_seen), .defer_exc(defer_exc),
    .late_hit(late_hit)
  );

  // per-frame event accumulators and byte total
  always_ff @(posedge clk) begin
    if (rst || frame_new) begin
      late_acc <= 1'b0;
      undr_acc <= 1'b0;
      total    <= '0;
    end else begin
      if (late_hit) late_acc <= 1'b1;
      if (underrun) undr_acc <= 1'b1;
      if (tx_vld)   total    <= total + 1'b1;
    end
  end

  assign frame_end = frame_done | frame_abort;

  always_comb begin
    rec           = '0;
    rec.done      = frame_done & ~frame_abort;
    rec.max_col   = frame_abort;
    rec.bcast     = is_bcast;
    rec.mcast     = is_mcast;
    rec.vlan      = is_vlan;
    rec.len_oor   = len_oor;
    rec.len_chk   = len_bad & frame_done & ~frame_abort;
    rec.exc_defer = defer_exc;
    rec.pkt_defer = defer_seen & ~defer_exc;
    rec.late_col  = late_acc;
    rec.underrun  = undr_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_r     <= '0;
      stat_bytes <= '0;
    end else if (frame_end) begin
      stat_r     <= rec;
      stat_bytes <= total;
    end
  end

  assign stat_flags = stat_r;

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(stat_flags) && $stable(stat_bytes));  // R2
  AST_DONE_MARK: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_abort) |=> stat_flags[0] && !stat_flags[9]);  // R3
  AST_ABORT_MARK: assert property (@(posedge clk) disable iff (rst)
    frame_abort |=> stat_flags[9] && !stat_flags[0] && !stat_flags[5]);  // R3
  AST_CAST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stat_flags[1] && stat_flags[2]));  // R5
  AST_DEFER_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stat_flags[6] && stat_flags[7]));  // R9
  AST_LENCHK_CLASS: assert property (@(posedge clk) disable iff (rst)
    stat_flags[5] |-> !stat_flags[4] && !stat_flags[3]);  // R8
endmodule

// File: tb/tb_txsv_collect.sv
module tb_txsv_collect;
  localparam int LN = 20, LB = 50, WB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speed_100 = 1'b0, tick = 1'b1, frame_new = 1'b0, defer_active = 1'b0;
  logic attempt_start = 1'b0, tx_vld = 1'b0, collision = 1'b0, underrun = 1'b0;
  logic frame_done = 1'b0, frame_abort = 1'b0;
  logic [7:0]  tx_byte = 8'h00;
  logic [10:0] stat_flags;
  logic [15:0] stat_bytes;

  always #5 clk = ~clk;

  txsv_collect #(.DEF_LIM_NIB(LN), .DEF_LIM_BIT(LB), .WIN_BITS(WB)) dut (
    .clk(clk), .rst(rst), .speed_100(speed_100), .tick(tick), .frame_new(frame_new),
    .defer_active(defer_active), .attempt_start(attempt_start), .tx_vld(tx_vld),
    .tx_byte(tx_byte), .collision(collision), .underrun(underrun),
    .frame_done(frame_done), .frame_abort(frame_abort),
    .stat_flags(stat_flags), .stat_bytes(stat_bytes));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // scenario of the current frame
  bit          sp, ab, ur;
  logic [47:0] da;
  logic [15:0] tf;
  int          nd, dt, ncol;
  int          cpos [8];

  function automatic logic [7:0] fbyte(int b);
    if (b < 6)  return da[47-8*b -: 8];
    if (b < 12) return 8'h22;
    if (b == 12) return tf[15:8];
    if (b == 13) return tf[7:0];
    return 8'(b);
  endfunction

  function automatic int max_sent();
    int m = ab ? 0 : 14 + nd;
    for (int i = 0; i < ncol; i++) if (cpos[i] > m) m = cpos[i];
    return m;
  endfunction

  function automatic logic [10:0] exp_flags();
    logic [10:0] f = '0;
    int ms = max_sent();
    int lim = sp ? LN : LB;
    int win = sp ? WB / 4 : WB;
    bit tv = (ms >= 14);
    f[0]  = !ab;
    f[1]  = (da == 48'hFFFF_FFFF_FFFF) && ms >= 6;
    f[2]  = ms >= 1 && da[40] && !f[1];
    f[3]  = tv && tf == 16'h8100;
    f[4]  = tv && tf > 16'd1500;
    f[5]  = !ab && tf <= 16'd1500 && nd != int'(tf) && !(tf < 16'd46 && nd == 46);
    f[6]  = dt > 0 && dt <= lim;
    f[7]  = dt > lim;
    for (int i = 0; i < ncol; i++) if (cpos[i] >= win) f[8] = 1'b1;
    f[9]  = ab;
    f[10] = ur;
    return f;
  endfunction

  function automatic logic [15:0] exp_bytes();
    int s = ab ? 0 : 14 + nd;
    for (int i = 0; i < ncol; i++) s += cpos[i];
    return 16'(s);
  endfunction

  function automatic string tag_of(int b);
    case (b)
      0, 9: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6, 7: return "R9";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk_flags(logic [10:0] exp, string what);
    n_chk++;
    if (stat_flags !== exp) begin
      n_bad++;
      for (int b = 0; b < 11; b++)
        if (stat_flags[b] !== exp[b])
          $display("FAIL %s (%s) flag bit %0d: got %b exp %b", tag_of(b), what, b, stat_flags[b], exp[b]);
    end
  endtask

  task automatic chk_val(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic run_frame();
    speed_100 = sp;
    frame_new = 1'b1; @(negedge clk); frame_new = 1'b0;
    for (int i = 0; i < dt; i++) begin
      defer_active = 1'b1; tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
    defer_active = 1'b0; tick = 1'b1; @(negedge clk);
    for (int a = 0; a < ncol; a++) begin
      attempt_start = 1'b1; @(negedge clk); attempt_start = 1'b0;
      for (int b = 0; b < cpos[a]; b++) begin
        tx_vld = 1'b1; tx_byte = fbyte(b); @(negedge clk);
      end
      tx_vld = 1'b0; collision = 1'b1; @(negedge clk); collision = 1'b0;
    end
    if (ab) begin
      if (ur) begin underrun = 1'b1; @(negedge clk); underrun = 1'b0; end
      frame_abort = 1'b1; @(negedge clk); frame_abort = 1'b0;
    end else begin
      attempt_start = 1'b1; @(negedge clk); attempt_start = 1'b0;
      for (int b = 0; b < 14 + nd; b++) begin
        tx_vld = 1'b1; tx_byte = fbyte(b); @(negedge clk);
        if (ur && b == 3) begin tx_vld = 1'b0; underrun = 1'b1; @(negedge clk); underrun = 1'b0; end
      end
      tx_vld = 1'b0; frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    end
  endtask

  task automatic plain(bit s, logic [47:0] d, logic [15:0] t, int n);
    sp = s; da = d; tf = t; nd = n; dt = 0; ncol = 0; ab = 0; ur = 0;
  endtask

  task automatic run_check(string what);
    run_frame();
    chk_flags(exp_flags(), what);
    chk_val("R12", 32'(stat_bytes), 32'(exp_bytes()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_val("R1 flags", 32'(stat_flags), 32'h0);
    chk_val("R1 bytes", 32'(stat_bytes), 32'h0);

    // R4: broadcast with matching length
    plain(1, 48'hFFFF_FFFF_FFFF, 16'd20, 20); run_check("R4 bcast");
    // R5: first byte odd but not all ones
    plain(0, 48'hFFFF_FFFF_FFFE, 16'd30, 30); run_check("R5 mcast");
    // R8: short field padded to 46 matches, 45 does not
    plain(0, 48'h0200_0000_0001, 16'd10, 46); run_check("R8 padded");
    plain(0, 48'h0200_0000_0001, 16'd10, 45); run_check("R8 short");
    // R6/R7: 0x8100 and first value above the limit
    plain(1, 48'h0300_0000_0002, 16'h8100, 5); run_check("R6 vlan");
    plain(1, 48'h0400_0000_0003, 16'd1501, 5); run_check("R7 1501");
    // R9: defer boundaries at both speeds
    for (int s = 0; s < 2; s++) begin
      plain(s[0], 48'h0600_0000_0000, 16'h0800, 2);
      dt = s[0] ? LN : LB;     run_check("R9 at limit");
      dt = (s[0] ? LN : LB) + 1; run_check("R9 over limit");
    end
    // R10: window boundaries; R13: late flag survives a clean retry
    for (int s = 0; s < 2; s++) begin
      plain(s[0], 48'h0800_0000_0000, 16'h0800, 3);
      ncol = 1; cpos[0] = (s[0] ? WB / 4 : WB) - 1; run_check("R10 below window");
      cpos[0] = s[0] ? WB / 4 : WB;               run_check("R10 R13 at window");
    end
    // R3: abort after two collisions
    plain(0, 48'hFFFF_FFFF_FFFF, 16'd7, 0);
    ab = 1; ncol = 2; cpos[0] = 3; cpos[1] = 8; run_check("R3 abort");
    // R11: underrun
    plain(1, 48'h0A00_0000_0000, 16'd4, 4); ur = 1; run_check("R11 underrun");
    // R2: new frame in flight leaves the record untouched
    frame_new = 1'b1; @(negedge clk); frame_new = 1'b0;
    attempt_start = 1'b1; @(negedge clk); attempt_start = 1'b0;
    for (int b = 0; b < 8; b++) begin tx_vld = 1'b1; tx_byte = 8'hFF; @(negedge clk); end
    tx_vld = 1'b0; collision = 1'b1; @(negedge clk); collision = 1'b0;
    chk_flags(exp_flags(), "R2 hold");
    chk_val("R2 hold bytes", 32'(stat_bytes), 32'(exp_bytes()));
    // R12: byte total wraps
    plain(1, 48'h0C00_0000_0000, 16'h0800, 65530); run_check("R12 wrap");

    for (int k = 0; k < 150; k++) begin
      int kind = $urandom % 3;
      int tk = $urandom % 5;
      sp = $urandom % 2;
      case (kind)
        0: da = 48'hFFFF_FFFF_FFFF;
        1: da = {8'($urandom) | 8'h01, 8'($urandom), 32'($urandom)};
        default: da = {8'($urandom) & 8'hFE, 8'($urandom), 32'($urandom)};
      endcase
      nd = $urandom % 80;
      case (tk)
        0: tf = 16'(nd);
        1: tf = 16'($urandom % 1501);
        2: tf = 16'h8100;
        3: tf = 16'(1501 + $urandom % 40);
        default: begin tf = 16'($urandom % 46); nd = 46; end
      endcase
      dt = ($urandom % 3 == 0) ? 0 : $urandom % 60;
      ncol = $urandom % 4;
      for (int i = 0; i < ncol; i++) cpos[i] = $urandom % 75;
      ab = ($urandom % 6 == 0);
      ur = ($urandom % 5 == 0);
      run_check("random R3-R13");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule